// File: doc/BRIEF.md
# Serial NAND Bring-Up Sequencer

After reset this block walks a serial NAND flash through the steps that make it usable. It drives a byte-wide SPI master through a request/acknowledge handshake and controls the chip select. First it issues a device reset. It then polls the status register until the device is idle and reads the two identification bytes. From those bytes it decides whether the part is supported and how many erase blocks it has. On a supported part it switches on the flash's internal ECC, waits for idle again, and removes all block write protection.

Each command goes out in its own chip-select frame, with an enforced idle gap between frames. When the sequence ends, the block raises a completion flag. On success it also presents the erase-block count and the base-two exponents of the page and erase-block sizes, for use by the logic that issues later flash commands. On an unsupported part it stops with the device-valid flag low and sends nothing further.

Top module: `nand_bringup_seq`

## Requirements
- R1: The first frame after reset is the single byte 0xFF.
- R2: A status poll is the frame 0x0F, 0xC0, 0x00, and the byte returned during the third byte slot is the status. The poll frame is repeated for as long as bit 0 of that status is 1. Only bit 0 decides whether the poll repeats.
- R3: After the first idle status comes the identify frame 0x9F, 0x00, 0x00, 0x00. The byte returned in slot 3 is the manufacturer and the byte returned in slot 4 is the device code.
- R4: If the manufacturer byte is not 0xC8, the sequence ends with seqDone=1 and devValid=0, and no further frame is sent.
- R5: Bits 3:0 of the device code select the erase-block count: 1 gives 1024, 2 gives 2048 and 4 gives 4096. Any other value ends the sequence as in R4.
- R6: On a supported part the next three frames are [0x06], then [0x1F, 0xB0, 0x10], then [0x04]. Together they enable ECC.
- R7: After the ECC frames, status is polled as in R2 until idle, and only then does the unlock step start.
- R8: The unlock step is [0x06], then [0x1F, 0xA0, 0x00], then [0x04]. After it, seqDone=1 and devValid=1.
- R9: Between any two frames spiCs stays low for at least CS_GAP clock cycles. spiReq is high only while spiCs is high, and spiTx holds steady while a byte waits for its acknowledge.
- R10: While devValid is 0, blockCount, pageShift and blockShift are 0. While devValid is 1, pageShift is 11 and blockShift is 17.
- R11: Once seqDone is 1 it stays 1, and spiCs stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spiCs | output | 1 | Chip select to the SPI master, 1 = selected |
| spiReq | output | 1 | Byte transfer request, held until acknowledged |
| spiTx | output | 8 | Byte to shift out |
| spiDone | input | 1 | One-cycle acknowledge that a byte has been exchanged |
| spiRx | input | 8 | Byte shifted in, valid with spiDone |
| seqDone | output | 1 | Sequence finished, either successfully or with an error |
| devValid | output | 1 | A supported device was found and set up |
| blockCount | output | 13 | Number of erase blocks |
| pageShift | output | 5 | log2 of the page size in bytes |
| blockShift | output | 5 | log2 of the erase-block size in bytes |

## Verification
The hardest situations to reach from the ports are a status poll that repeats several times, especially the second poll after the ECC write, and the early stop on each possible identification failure. The bench drives the SPI side with a behavioural flash model. For each run it is told how many busy replies to give in each polling phase and which identification bytes to return. Busy replies carry only bit 0 set and idle replies carry every other bit set, so only bit 0 can decide whether a poll repeats. A sweep over every low-nibble device code, three manufacturer values, varied busy counts and acknowledge latencies reaches each branch. Every frame the model captures is compared against a frame list the bench builds from the requirements.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int MIN_BLK_LOG2 = 10;
  localparam int CNT_W        = MIN_BLK_LOG2 + 3;
  localparam int SHIFT_W      = 5;
  localparam int STEP_W       = 4;
  localparam int NUM_STEPS    = 10;
  localparam int IDX_W        = 3;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_GETFEAT = 8'h0F;
  localparam logic [7:0] OP_SETFEAT = 8'h1F;
  localparam logic [7:0] OP_IDENT   = 8'h9F;
  localparam logic [7:0] OP_WRON    = 8'h06;
  localparam logic [7:0] OP_WROFF   = 8'h04;
  localparam logic [7:0] FA_STATUS  = 8'hC0;
  localparam logic [7:0] FA_CONFIG  = 8'hB0;
  localparam logic [7:0] FA_PROTECT = 8'hA0;
  localparam logic [7:0] CFG_ECC    = 8'h10;
  localparam logic [7:0] VENDOR_OK  = 8'hC8;

  typedef enum logic [2:0] {
    FK_RESET, FK_POLL, FK_IDENT, FK_WRON, FK_SETF, FK_WROFF
  } frameKind_t;

  typedef struct packed {
    logic       byteClr;
    logic       byteInc;
    logic       capture;
    logic       setValid;
    frameKind_t kind;
    logic [7:0] featAddr;
    logic [7:0] featData;
  } dpCtl_t;

  function automatic logic [IDX_W-1:0] frameLast(input frameKind_t k);
    case (k)
      FK_POLL:  return IDX_W'(2);
      FK_IDENT: return IDX_W'(3);
      FK_SETF:  return IDX_W'(2);
      default:  return IDX_W'(0);
    endcase
  endfunction

  function automatic frameKind_t stepKind(input logic [STEP_W-1:0] s);
    case (s)
      4'd0:          return FK_RESET;
      4'd1, 4'd6:    return FK_POLL;
      4'd2:          return FK_IDENT;
      4'd3, 4'd7:    return FK_WRON;
      4'd4, 4'd8:    return FK_SETF;
      default:       return FK_WROFF;
    endcase
  endfunction

  function automatic logic [7:0] stepAddr(input logic [STEP_W-1:0] s);
    return (s == 4'd4) ? FA_CONFIG : FA_PROTECT;
  endfunction

  function automatic logic [7:0] stepData(input logic [STEP_W-1:0] s);
    return (s == 4'd4) ? CFG_ECC : 8'h00;
  endfunction

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int PAGE_LOG2  = 11,
  parameter int BLOCK_LOG2 = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtl_t           ctl,
  input  logic [7:0]       rxByte,
  output logic [7:0]       txByte,
  output logic             lastByte,
  output logic             devBusy,
  output logic             idGood,
  output logic             validOut,
  output logic [CNT_W-1:0] countOut,
  output logic [SHIFT_W-1:0] pageOut,
  output logic [SHIFT_W-1:0] blockOut
);

  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       statusReg;
  logic [7:0]       vendorReg;
  logic [7:0]       deviceReg;
  logic [1:0]       sizeLog;
  logic             sizeOk;
  logic             validReg;
  logic [CNT_W-1:0] countReg;

  always_ff @(posedge clk) begin
    if (rst) byteIdx <= '0;
    else if (ctl.byteClr) byteIdx <= '0;
    else if (ctl.byteInc) byteIdx <= byteIdx + 1'b1;
  end

  always_comb begin
    txByte = 8'h00;
    case (ctl.kind)
      FK_RESET: txByte = OP_RESET;
      FK_POLL: begin
        if (byteIdx == 0) txByte = OP_GETFEAT;
        else if (byteIdx == 1) txByte = FA_STATUS;
      end
      FK_IDENT: if (byteIdx == 0) txByte = OP_IDENT;
      FK_WRON:  txByte = OP_WRON;
      FK_WROFF: txByte = OP_WROFF;
      FK_SETF: begin
        if (byteIdx == 0) txByte = OP_SETFEAT;
        else if (byteIdx == 1) txByte = ctl.featAddr;
        else txByte = ctl.featData;
      end
      default: txByte = 8'h00;
    endcase
  end

  assign lastByte = (byteIdx == frameLast(ctl.kind));

  always_ff @(posedge clk) begin
    if (rst) begin
      statusReg <= '0;
      vendorReg <= '0;
      deviceReg <= '0;
    end else if (ctl.capture) begin
      if (ctl.kind == FK_POLL && byteIdx == 2) statusReg <= rxByte;
      if (ctl.kind == FK_IDENT && byteIdx == 2) vendorReg <= rxByte;
      if (ctl.kind == FK_IDENT && byteIdx == 3) deviceReg <= rxByte;
    end
  end

  always_comb begin
    sizeOk  = 1'b1;
    sizeLog = 2'd0;
    case (deviceReg[3:0])
      4'd1: sizeLog = 2'd0;
      4'd2: sizeLog = 2'd1;
      4'd4: sizeLog = 2'd2;
      default: sizeOk = 1'b0;
    endcase
  end

  assign devBusy = statusReg[0];
  assign idGood  = (vendorReg == VENDOR_OK) && sizeOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      validReg <= 1'b0;
      countReg <= '0;
    end else if (ctl.setValid) begin
      validReg <= 1'b1;
      countReg <= {{(CNT_W-1){1'b0}}, 1'b1} << (MIN_BLK_LOG2 + int'(sizeLog));
    end
  end

  assign validOut = validReg;
  assign countOut = validReg ? countReg : '0;
  assign pageOut  = validReg ? SHIFT_W'(PAGE_LOG2) : '0;
  assign blockOut = validReg ? SHIFT_W'(BLOCK_LOG2) : '0;

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int CS_GAP = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   xferAck,
  input  logic   lastByte,
  input  logic   devBusy,
  input  logic   idGood,
  output dpCtl_t ctl,
  output logic   csOn,
  output logic   reqOn,
  output logic   finished
);

  localparam int GAP_W = (CS_GAP < 2) ? 1 : $clog2(CS_GAP);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [2:0] {ST_GAP, ST_XFER, ST_EVAL, ST_DONE, ST_FAIL} state_t;

  state_t            state, stateNext;
  logic [STEP_W-1:0] step, stepNext;
  logic [GAP_W-1:0]  gapCnt;
  frameKind_t        kind;

  assign kind = stepKind(step);

  always_comb begin
    stateNext    = state;
    stepNext     = step;
    ctl          = '0;
    ctl.kind     = kind;
    ctl.featAddr = stepAddr(step);
    ctl.featData = stepData(step);
    case (state)
      ST_GAP: begin
        ctl.byteClr = 1'b1;
        if (gapCnt == GAP_W'(CS_GAP - 1)) stateNext = ST_XFER;
      end
      ST_XFER: begin
        if (xferAck) begin
          ctl.capture = 1'b1;
          if (lastByte) stateNext = ST_EVAL;
          else ctl.byteInc = 1'b1;
        end
      end
      ST_EVAL: begin
        if (kind == FK_POLL && devBusy) begin
          stateNext = ST_GAP;
        end else if (kind == FK_IDENT && !idGood) begin
          stateNext = ST_FAIL;
        end else if (step == LAST_STEP) begin
          ctl.setValid = 1'b1;
          stateNext    = ST_DONE;
        end else begin
          stepNext  = step + 1'b1;
          stateNext = ST_GAP;
        end
      end
      default: stateNext = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_GAP;
      step   <= '0;
      gapCnt <= '0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
      if (state == ST_GAP && stateNext == ST_GAP) gapCnt <= gapCnt + 1'b1;
      else gapCnt <= '0;
    end
  end

  assign csOn     = (state == ST_XFER);
  assign reqOn    = (state == ST_XFER);
  assign finished = (state == ST_DONE) || (state == ST_FAIL);

endmodule

// File: rtl/nand_bringup_seq.sv
module nand_bringup_seq
  import nand_seq_pkg::*;
#(
  parameter int CS_GAP     = 3,
  parameter int PAGE_LOG2  = 11,
  parameter int BLOCK_LOG2 = 17
) (
  input  logic               clk,
  input  logic               rst,
  output logic               spiCs,
  output logic               spiReq,
  output logic [7:0]         spiTx,
  input  logic               spiDone,
  input  logic [7:0]         spiRx,
  output logic               seqDone,
  output logic               devValid,
  output logic [CNT_W-1:0]   blockCount,
  output logic [SHIFT_W-1:0] pageShift,
  output logic [SHIFT_W-1:0] blockShift
);

  dpCtl_t ctl;
  logic   lastByte;
  logic   devBusy;
  logic   idGood;

  nand_seq_ctrl #(.CS_GAP(CS_GAP)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .xferAck  (spiDone),
    .lastByte (lastByte),
    .devBusy  (devBusy),
    .idGood   (idGood),
    .ctl      (ctl),
    .csOn     (spiCs),
    .reqOn    (spiReq),
    .finished (seqDone)
  );

  nand_seq_dp #(.PAGE_LOG2(PAGE_LOG2), .BLOCK_LOG2(BLOCK_LOG2)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .rxByte   (spiRx),
    .txByte   (spiTx),
    .lastByte (lastByte),
    .devBusy  (devBusy),
    .idGood   (idGood),
    .validOut (devValid),
    .countOut (blockCount),
    .pageOut  (pageShift),
    .blockOut (blockShift)
  );

endmodule

// File: rtl/nand_bringup_seq_chk.sv
module nand_bringup_seq_chk
  import nand_seq_pkg::*;
#(
  parameter int CS_GAP     = 3,
  parameter int PAGE_LOG2  = 11,
  parameter int BLOCK_LOG2 = 17
) (
  input logic               clk,
  input logic               rst,
  input logic               spiCs,
  input logic               spiReq,
  input logic [7:0]         spiTx,
  input logic               spiDone,
  input logic               seqDone,
  input logic               devValid,
  input logic [CNT_W-1:0]   blockCount,
  input logic [SHIFT_W-1:0] pageShift,
  input logic [SHIFT_W-1:0] blockShift
);

  logic [15:0] lowCnt;
  logic        hadFrame;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowCnt   <= '0;
      hadFrame <= 1'b0;
    end else begin
      if (spiCs) lowCnt <= '0;
      else if (lowCnt != 16'hFFFF) lowCnt <= lowCnt + 1'b1;
      if (spiCs) hadFrame <= 1'b1;
    end
  end

  p_req_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    spiReq |-> spiCs);

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(spiCs) && hadFrame) |-> (lowCnt >= 16'(CS_GAP)));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (spiReq && !spiDone) |=> (spiReq && $stable(spiTx)));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    seqDone |=> seqDone);

  p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (rst)
    seqDone |-> (!spiCs && !spiReq));

  p_valid_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
    devValid |-> seqDone);

  p_count_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    devValid |-> ($countones(blockCount) == 1));

  p_shifts_r10: assert property (@(posedge clk) disable iff (rst)
    devValid |-> (pageShift == SHIFT_W'(PAGE_LOG2) && blockShift == SHIFT_W'(BLOCK_LOG2)));

  p_zero_outputs_r10: assert property (@(posedge clk) disable iff (rst)
    !devValid |-> (blockCount == '0 && pageShift == '0 && blockShift == '0));

endmodule

bind nand_bringup_seq nand_bringup_seq_chk #(
  .CS_GAP(CS_GAP), .PAGE_LOG2(PAGE_LOG2), .BLOCK_LOG2(BLOCK_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .spiCs(spiCs), .spiReq(spiReq), .spiTx(spiTx),
  .spiDone(spiDone), .seqDone(seqDone), .devValid(devValid),
  .blockCount(blockCount), .pageShift(pageShift), .blockShift(blockShift)
);

// File: tb/nand_bringup_seq_tb.sv
`timescale 1ns/1ps
module nand_bringup_seq_tb;
  import nand_seq_pkg::*;

  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spiCs, spiReq, spiDone, seqDone, devValid;
  logic [7:0] spiTx, spiRx;
  logic [CNT_W-1:0] blockCount;
  logic [SHIFT_W-1:0] pageShift, blockShift;

  always #4 clk = ~clk;

  nand_bringup_seq #(.CS_GAP(GAP)) u_dut (
    .clk(clk), .rst(rst), .spiCs(spiCs), .spiReq(spiReq), .spiTx(spiTx),
    .spiDone(spiDone), .spiRx(spiRx), .seqDone(seqDone), .devValid(devValid),
    .blockCount(blockCount), .pageShift(pageShift), .blockShift(blockShift)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // flash model settings and capture
  int mLat = 1, mBusy1 = 0, mBusy2 = 0, busyLeft = 0;
  logic [7:0] mVendor = 8'hC8, mDevice = 8'h01;
  logic [7:0] obsB [64][4];
  int obsL [64];
  int obsN = 0, curLen = 0, lowRun = 0, minGap = 1000, waitCnt = 0;
  bit inFrame = 0, reqNoCs = 0;

  logic [7:0] expB [32][4];
  int expL [32];
  string expTag [32];
  int expN = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    spiDone = 1'b0;
    spiRx   = 8'h00;
    forever begin
      @(negedge clk);
      spiDone = 1'b0;
      if (spiReq && !spiCs) reqNoCs = 1;
      if (!spiCs) begin
        if (inFrame) begin
          inFrame = 0;
          if (obsN < 64) begin
            obsL[obsN] = curLen;
            if (curLen == 3 && obsB[obsN][0] == OP_SETFEAT && obsB[obsN][1] == FA_CONFIG)
              busyLeft = mBusy2;
          end
          obsN++;
          lowRun = 0;
        end
        lowRun++;
        waitCnt = 0;
      end else begin
        if (!inFrame) begin
          inFrame = 1;
          curLen = 0;
          if (obsN > 0 && lowRun < minGap) minGap = lowRun;
        end
        if (spiReq) begin
          if (waitCnt < mLat) waitCnt++;
          else begin
            logic [7:0] cmd;
            waitCnt = 0;
            cmd = (curLen == 0 || obsN >= 64) ? spiTx : obsB[obsN][0];
            if (obsN < 64 && curLen < 4) obsB[obsN][curLen] = spiTx;
            spiRx = 8'hA5;
            if (cmd == OP_GETFEAT && curLen == 2) begin
              if (busyLeft > 0) begin busyLeft--; spiRx = 8'h01; end
              else spiRx = 8'hFE;
            end
            if (cmd == OP_IDENT && curLen == 2) spiRx = mVendor;
            if (cmd == OP_IDENT && curLen == 3) spiRx = mDevice;
            curLen++;
            spiDone = 1'b1;
          end
        end
      end
    end
  end

  task automatic addF(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic [7:0] d, input int len, input string tag);
    expB[expN][0] = a; expB[expN][1] = b; expB[expN][2] = c; expB[expN][3] = d;
    expL[expN] = len; expTag[expN] = tag; expN++;
  endtask

  task automatic runCase(input logic [7:0] vend, input logic [7:0] dev,
                         input int b1, input int b2, input int lat);
    bit ok;
    int cnt, cyc;
    ok = (vend == 8'hC8) && (dev[3:0] == 4'd1 || dev[3:0] == 4'd2 || dev[3:0] == 4'd4);
    cnt = (dev[3:0] == 4'd1) ? 1024 : (dev[3:0] == 4'd2) ? 2048 : 4096;
    @(posedge clk); #1;
    rst = 1'b1;
    mVendor = vend; mDevice = dev; mBusy1 = b1; mBusy2 = b2; mLat = lat;
    busyLeft = b1; obsN = 0; curLen = 0; lowRun = 0; minGap = 1000;
    inFrame = 0; reqNoCs = 0; waitCnt = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!seqDone && !devValid && !spiCs && blockCount == 0 && pageShift == 0,
        "R10", "reset state", {seqDone, devValid, spiCs}, 0);
    expN = 0;
    addF(8'hFF, 0, 0, 0, 1, "R1");
    for (int i = 0; i <= b1; i++) addF(8'h0F, 8'hC0, 8'h00, 0, 3, "R2");
    addF(8'h9F, 0, 0, 0, 4, "R3");
    if (ok) begin
      addF(8'h06, 0, 0, 0, 1, "R6");
      addF(8'h1F, 8'hB0, 8'h10, 0, 3, "R6");
      addF(8'h04, 0, 0, 0, 1, "R6");
      for (int i = 0; i <= b2; i++) addF(8'h0F, 8'hC0, 8'h00, 0, 3, "R7");
      addF(8'h06, 0, 0, 0, 1, "R8");
      addF(8'h1F, 8'hA0, 8'h00, 0, 3, "R8");
      addF(8'h04, 0, 0, 0, 1, "R8");
    end
    rst = 1'b0;
    cyc = 0;
    while (!seqDone && cyc < 4000) begin @(posedge clk); #1; cyc++; end
    chk(seqDone == 1'b1, "R11", "sequence completion", seqDone, 1);
    repeat (40) @(posedge clk);
    #1;
    chk(obsN == expN, ok ? "R11" : "R4", "frame count", obsN, expN);
    for (int i = 0; i < expN && i < obsN; i++) begin
      bit same;
      same = (obsL[i] == expL[i]);
      for (int j = 0; j < expL[i] && j < 4; j++)
        if (obsB[i][j] != expB[i][j]) same = 0;
      chk(same, expTag[i], $sformatf("frame %0d content", i),
          {obsB[i][0], obsB[i][1], obsB[i][2], obsB[i][3]},
          {expB[i][0], expB[i][1], expB[i][2], expB[i][3]});
    end
    chk(devValid == ok, ok ? "R8" : (vend != 8'hC8 ? "R4" : "R5"), "devValid", devValid, ok);
    chk(seqDone == 1'b1 && !spiCs, "R11", "done and deselected", {seqDone, spiCs}, 2);
    chk(blockCount == (ok ? CNT_W'(cnt) : '0), "R5", "blockCount", blockCount, ok ? cnt : 0);
    chk(pageShift == (ok ? 5'd11 : 5'd0) && blockShift == (ok ? 5'd17 : 5'd0), "R10",
        "size exponents", {pageShift, blockShift}, ok ? {5'd11, 5'd17} : 0);
    chk(minGap >= GAP && !reqNoCs, "R9", "chip-select gap", minGap, GAP);
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < 16; n++) begin
        logic [7:0] v, d;
        v = (m == 0) ? 8'hC8 : (m == 1) ? 8'hC9 : 8'h48;
        d = {4'((n * 5 + m) & 15), 4'(n)};
        runCase(v, d, (n + m) % 3, (n * 2 + m) % 3, (n + m) % 3 + 1);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule